// File: doc/BRIEF.md
# Multi-input wake-up debounce controller

This block turns a set of slow wake-up lines into a single request to bring up the core power supply. Each line has its own enable and its own active level. The enabled lines are merged into one combined active condition. That condition must then hold for a selectable number of slow-clock periods before the block accepts it as a wake-up. The whole block runs on the slow clock.

When the debouncer accepts a wake-up, two things are recorded until the status is read. The first is a sticky pin-wake flag. The second is a snapshot of which enabled lines were at their active level at that moment. A read strobe clears both. Two alarm inputs, one from a calendar clock and one from a counter timer, can also raise the wake-up request, each behind its own enable. The request stays high until the core reports that it is awake.

Top module: `wk_wake_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `wake_req`, `pin_flag` and `pin_snap` are all 0.
- R2: Line i is active when `line_en[i]` is 1 and `wake_in[i]` equals `line_pol[i]`. A `line_pol[i]` of 1 selects high-active and 0 selects low-active. A line with `line_en[i]` of 0 never causes a wake-up, whatever its level.
- R3: The `dbc_sel` code selects how many consecutive clock edges the combined condition must be sampled active before the debouncer fires: 0→1, 1→3, 2→32, 3→512, 4→4096, and 5, 6 and 7→32768. With one edge fewer, nothing fires. The outputs change on the edge that fires.
- R4: If the combined condition is sampled inactive on any edge, the count restarts from zero.
- R5: The debouncer fires at most once per active episode. After it fires, it can fire again only once the combined condition has been sampled inactive.
- R6: `pin_flag` is set on the edge that fires and stays set until an edge at which `stat_rd` is 1. If a fire and a read land on the same edge, the flag stays set.
- R7: `pin_snap[i]` is set for each line that is active on a firing edge. The bits accumulate across fires until a read clears them. On an edge that both reads and fires, the snapshot holds only the lines of the new fire.
- R8: On the next edge, `rtc_alarm` with `rtc_en` set raises `wake_req`, and `tmr_alarm` with `tmr_en` set does the same. Without its enable, an alarm has no effect. Alarms never set `pin_flag`.
- R9: `wake_req` rises on the firing edge and then holds until an edge at which `core_awake` is 1 and no new wake-up source is present. A new wake-up source takes precedence over `core_awake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | NUM_IN | Raw wake-up line levels |
| line_en | input | NUM_IN | Per-line enable |
| line_pol | input | NUM_IN | Per-line active level (1 high, 0 low) |
| dbc_sel | input | 3 | Debounce length code |
| rtc_en | input | 1 | Calendar alarm wake enable |
| rtc_alarm | input | 1 | Calendar alarm |
| tmr_en | input | 1 | Timer alarm wake enable |
| tmr_alarm | input | 1 | Timer alarm |
| stat_rd | input | 1 | Status read strobe, clears flag and snapshot |
| core_awake | input | 1 | Core-awake acknowledge, drops the request |
| wake_req | output | 1 | Wake-up request to the power sequencer |
| pin_flag | output | 1 | Sticky pin wake-up flag |
| pin_snap | output | NUM_IN | Lines active at the debounce completion |

## Verification
The bench sweeps all eight debounce codes. For each code it holds a line active for one edge fewer than the length and confirms that nothing fires, then confirms that the next edge fires. An off-by-one counter would fire early or late, and a bad decode for the spare codes would give a wrong length. It sweeps every line in both polarities while the other lines sit at their active level but are disabled. A polarity or enable mix-up would then fire on the wrong line or report the wrong snapshot. It also covers a glitch in mid-count, a line held active after its status is read, a read that coincides with a fire, and an alarm that persists while `core_awake` is asserted. A missing restart, a missing edge lock, a read that takes priority, or an acknowledge that takes priority would each show up at the outputs.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [2:0] {
        DBC_NOW  = 3'd0,
        DBC_3    = 3'd1,
        DBC_32   = 3'd2,
        DBC_512  = 3'd3,
        DBC_4K   = 3'd4,
        DBC_32K  = 3'd5,
        DBC_SP6  = 3'd6,
        DBC_SP7  = 3'd7
    } dbc_code_t;

    localparam int unsigned LONGEST_PERIOD = 32768;

    // Number of consecutive active edges needed for a given code.
    function automatic int unsigned dbc_periods(input logic [2:0] code);
        case (dbc_code_t'(code))
            DBC_NOW: return 1;
            DBC_3:   return 3;
            DBC_32:  return 32;
            DBC_512: return 512;
            DBC_4K:  return 4096;
            default: return LONGEST_PERIOD;
        endcase
    endfunction

endpackage

// File: rtl/wk_match.sv
module wk_match #(
    parameter int NUM_IN = 14
) (
    input  logic [NUM_IN-1:0] lvl,
    input  logic [NUM_IN-1:0] en,
    input  logic [NUM_IN-1:0] pol,
    output logic [NUM_IN-1:0] hit
);
    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        assign hit[g] = en[g] & (lvl[g] ~^ pol[g]);
    end
endmodule

// File: rtl/wk_debounce.sv
module wk_debounce #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;
    logic             locked;

    always_comb fire = active && !locked && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (!active) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            if (cnt != limit) cnt <= cnt + 1'b1;
            if (fire) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/wk_status.sv
module wk_status #(
    parameter int NUM_IN = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [NUM_IN-1:0] hit,
    input  logic              rd,
    output logic              flag,
    output logic [NUM_IN-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            snap <= '0;
        end else if (fire) begin
            flag <= 1'b1;
            snap <= (rd ? '0 : snap) | hit;
        end else if (rd) begin
            flag <= 1'b0;
            snap <= '0;
        end
    end
endmodule

// File: rtl/wk_wake_ctrl.sv
module wk_wake_ctrl #(
    parameter int NUM_IN     = 14,
    parameter int MAX_PERIOD = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] wake_in,
    input  logic [NUM_IN-1:0] line_en,
    input  logic [NUM_IN-1:0] line_pol,
    input  logic [2:0]        dbc_sel,
    input  logic              rtc_en,
    input  logic              rtc_alarm,
    input  logic              tmr_en,
    input  logic              tmr_alarm,
    input  logic              stat_rd,
    input  logic              core_awake,
    output logic              wake_req,
    output logic              pin_flag,
    output logic [NUM_IN-1:0] pin_snap
);
    import wk_pkg::*;

    localparam int CNT_W = $clog2(MAX_PERIOD) + 1;

    logic [NUM_IN-1:0] hit;
    logic              dbc_fire;
    logic [CNT_W-1:0]  limit;
    logic              alarm_set;

    assign limit     = CNT_W'(dbc_periods(dbc_sel) - 1);
    assign alarm_set = (rtc_en & rtc_alarm) | (tmr_en & tmr_alarm);

    wk_match #(.NUM_IN(NUM_IN)) u_match (
        .lvl (wake_in),
        .en  (line_en),
        .pol (line_pol),
        .hit (hit)
    );

    wk_debounce #(.CNT_W(CNT_W)) u_dbc (
        .clk    (clk),
        .rst    (rst),
        .active (|hit),
        .limit  (limit),
        .fire   (dbc_fire)
    );

    wk_status #(.NUM_IN(NUM_IN)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .fire (dbc_fire),
        .hit  (hit),
        .rd   (stat_rd),
        .flag (pin_flag),
        .snap (pin_snap)
    );

    always_ff @(posedge clk) begin
        if (rst)                         wake_req <= 1'b0;
        else if (dbc_fire || alarm_set)  wake_req <= 1'b1;
        else if (core_awake)             wake_req <= 1'b0;
    end
endmodule

// File: rtl/wk_wake_ctrl_chk.sv
module wk_wake_ctrl_chk #(
    parameter int NUM_IN = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              stat_rd,
    input logic              core_awake,
    input logic              rtc_en,
    input logic              rtc_alarm,
    input logic              tmr_en,
    input logic              tmr_alarm,
    input logic              fire,
    input logic              wake_req,
    input logic              pin_flag,
    input logic [NUM_IN-1:0] pin_snap
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wake_req && !pin_flag && pin_snap == '0));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (pin_flag && !stat_rd) |=> pin_flag);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !fire) |=> (!pin_flag && pin_snap == '0));

    a_r6_fire_sets: assert property (@(posedge clk) disable iff (rst)
        fire |=> pin_flag);

    a_r7_snap_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (pin_snap != '0) |-> pin_flag);

    a_r8_rtc_wakes: assert property (@(posedge clk) disable iff (rst)
        (rtc_en && rtc_alarm) |=> wake_req);

    a_r8_tmr_wakes: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && tmr_alarm) |=> wake_req);

    a_r9_req_holds: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !core_awake) |=> wake_req);
endmodule

bind wk_wake_ctrl wk_wake_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stat_rd    (stat_rd),
    .core_awake (core_awake),
    .rtc_en     (rtc_en),
    .rtc_alarm  (rtc_alarm),
    .tmr_en     (tmr_en),
    .tmr_alarm  (tmr_alarm),
    .fire       (dbc_fire),
    .wake_req   (wake_req),
    .pin_flag   (pin_flag),
    .pin_snap   (pin_snap)
);

// File: tb/test_wk_wake_ctrl.sv
module test_wk_wake_ctrl;
    localparam int N = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] wake_in = '0;
    logic [N-1:0] line_en = '0;
    logic [N-1:0] line_pol = '0;
    logic [2:0]   dbc_sel = 3'd0;
    logic         rtc_en = 1'b0, rtc_alarm = 1'b0;
    logic         tmr_en = 1'b0, tmr_alarm = 1'b0;
    logic         stat_rd = 1'b0, core_awake = 1'b0;
    logic         wake_req, pin_flag;
    logic [N-1:0] pin_snap;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wk_wake_ctrl #(.NUM_IN(N)) i_wk_wake_ctrl (
        .clk(clk), .rst(rst), .wake_in(wake_in), .line_en(line_en),
        .line_pol(line_pol), .dbc_sel(dbc_sel), .rtc_en(rtc_en),
        .rtc_alarm(rtc_alarm), .tmr_en(tmr_en), .tmr_alarm(tmr_alarm),
        .stat_rd(stat_rd), .core_awake(core_awake), .wake_req(wake_req),
        .pin_flag(pin_flag), .pin_snap(pin_snap)
    );

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        line_en = '0; rtc_alarm = 0; tmr_alarm = 0; rtc_en = 0; tmr_en = 0;
        stat_rd = 1; core_awake = 1;
        step(1);
        stat_rd = 0; core_awake = 0;
    endtask

    function automatic int exp_len(input int code);
        case (code)
            0: return 1;
            1: return 3;
            2: return 32;
            3: return 512;
            4: return 4096;
            default: return 32768;
        endcase
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        step(2);
        chk("R1 req in reset", wake_req, 0);
        chk("R1 flag in reset", pin_flag, 0);
        chk("R1 snap in reset", pin_snap, 0);
        rst = 0;
        step(1);
        chk("R1 req after reset", wake_req, 0);
        chk("R1 snap after reset", pin_snap, 0);

        // R3: length sweep over every code
        for (int c = 0; c < 8; c++) begin
            int t;
            t = exp_len(c);
            dbc_sel = 3'(c); line_pol = 14'h1; wake_in = '0; line_en = 14'h1;
            step(1);
            wake_in = 14'h1;
            step(t - 1);
            chk($sformatf("R3 code %0d early", c), pin_flag, 0);
            step(1);
            chk($sformatf("R3 code %0d fires", c), pin_flag, 1);
            chk($sformatf("R7 code %0d snap", c), pin_snap, 14'h1);
            chk($sformatf("R9 code %0d req", c), wake_req, 1);
            wake_in = '0;
            quiet();
        end

        // R2: every line, both polarities, others disabled yet active-level
        dbc_sel = 0;
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 2; p++) begin
                logic [N-1:0] bitm;
                bitm = 14'(1) << i;
                line_pol = p ? bitm : '0;
                wake_in = p ? '0 : bitm;
                line_en = bitm;
                step(2);
                chk($sformatf("R2 line %0d pol %0d idle", i, p), pin_flag, 0);
                wake_in = p ? bitm : '0;
                step(1);
                chk($sformatf("R2 line %0d pol %0d fire", i, p), pin_flag, 1);
                chk($sformatf("R7 line %0d pol %0d snap", i, p), pin_snap, 32'(bitm));
                quiet();
            end
        end

        // R4: glitch restarts count (code 1 = 3 edges)
        dbc_sel = 1; line_pol = 14'h1; wake_in = '0; line_en = 14'h1;
        step(1);
        wake_in = 14'h1; step(2);
        wake_in = '0;    step(1);
        wake_in = 14'h1; step(2);
        chk("R4 restart no early fire", pin_flag, 0);
        step(1);
        chk("R4 fires after full run", pin_flag, 1);

        // R5: held after read does not fire again
        stat_rd = 1; step(1); stat_rd = 0;
        chk("R6 read clears flag", pin_flag, 0);
        step(10);
        chk("R5 no refire while held", pin_flag, 0);
        wake_in = '0; step(1);
        wake_in = 14'h1; step(3);
        chk("R5 refire after drop", pin_flag, 1);
        wake_in = '0;
        quiet();

        // R7 accumulation and R6 read/fire collision
        dbc_sel = 0; line_pol = 14'h3; wake_in = '0; line_en = 14'h3;
        step(1);
        wake_in = 14'h1; step(1);
        wake_in = '0;    step(1);
        wake_in = 14'h2; step(1);
        chk("R7 snap accumulates", pin_snap, 14'h3);
        wake_in = '0; step(1);
        wake_in = 14'h2; stat_rd = 1; step(1); stat_rd = 0;
        chk("R6 fire beats read", pin_flag, 1);
        chk("R7 snap after read+fire", pin_snap, 14'h2);
        wake_in = '0; step(1);
        wake_in = 14'h3; step(1);
        chk("R7 both lines snap", pin_snap, 14'h3);
        wake_in = '0;
        quiet();

        // R8 alarms
        rtc_alarm = 1; step(2);
        chk("R8 rtc gated off", wake_req, 0);
        rtc_en = 1; step(1);
        chk("R8 rtc wakes", wake_req, 1);
        chk("R8 rtc no pin flag", pin_flag, 0);
        rtc_alarm = 0; step(5);
        chk("R9 req held", wake_req, 1);
        core_awake = 1; step(1); core_awake = 0;
        chk("R9 ack drops req", wake_req, 0);
        rtc_en = 0;
        tmr_alarm = 1; step(2);
        chk("R8 tmr gated off", wake_req, 0);
        tmr_en = 1; core_awake = 1; step(1);
        chk("R9 set beats ack", wake_req, 1);
        tmr_alarm = 0; step(1); core_awake = 0;
        chk("R9 ack after alarm gone", wake_req, 0);
        quiet();

        done = 1;
        summary();
    end
endmodule